// File: doc/BRIEF.md
# Two-Slot Serial Audio Receiver (64-bit frame, clock slave)

This block receives a stereo serial audio stream whose bit clock and frame sync are driven by an upstream source. Those two clocks follow the source's original sample rate. Each frame is 64 bit periods long and holds two 32-bit slots. The left slot is sent while frame sync is high and the right slot while it is low. Only the 16 least significant bits of each slot are kept, as a signed sample. The complete left/right pair is handed to the system-clock domain on a valid/ready stream.

The external bit clock, frame sync and data are oversampled in the system clock, and the bit clock's rising edges are detected there. The block tracks the bit position inside the frame and checks frame sync against that position on every bit. Two events make it drop what it holds and re-align to the next frame start: a misplaced frame-sync edge, as happens when the source changes rate between 44.1 kHz and 48 kHz, and a new pair arriving while the previous one is still unread.

Back-pressure rules: the stream cannot stall the serial source. A pair waits on `pair_valid` for as long as `pair_ready` is low, until the moment the next pair completes. If it is still unread then, the block raises `overrun` and drops the waiting pair. The new pair is dropped as well, and the receiver re-aligns.

Top module: `i2s64_slot_rx`

## Requirements
- R1: After reset `pair_valid`, `sync_err` and `overrun` are low. No pair is produced until frame sync has been seen low and then high on a bit-clock rising edge, so a frame already in progress at start-up is never emitted.
- R2: Frame sync and data are taken only at bit-clock rising edges. Changes while the bit clock is high do not affect the output. The system clock must run at least 8 times faster than the bit clock.
- R3: A frame is 64 bits, MSB first. Frame sync is high for bits 0..31, which form the left slot, and low for bits 32..63, which form the right slot.
- R4: Each output sample is bits 15:0 of its slot, as two's complement. Bits 31:16 of the slot have no effect on it.
- R5: With the default two synchroniser stages, a pair appears on `pair_valid`, `pair_left` and `pair_right` at the third system-clock rising edge after the bit-clock rise that carries bit 63 of the frame.
- R6: While `pair_valid` is high and `pair_ready` is low, the pair holds steady. A transfer (valid and ready both high) lowers `pair_valid` on the next cycle.
- R7: If a pair completes while the previous pair is still waiting, `overrun` pulses for one cycle and `pair_valid` drops. The receiver then waits for the next frame start, and the next complete frame is delivered normally.
- R8: If frame sync at any bit differs from the level R3 gives for that bit position, `sync_err` pulses for one cycle. The frame in progress is discarded and any waiting pair is dropped.
- R9: If the offending bit in R8 is itself a frame-sync rise, that bit starts a new frame at once. Otherwise the receiver waits for the next rise. Only complete frames that pass the R8 check produce pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | External bit clock |
| fsync_i | input | 1 | External frame sync, high during the left slot |
| sdata_i | input | 1 | Serial data, MSB first |
| pair_ready | input | 1 | Consumer accepts the waiting pair |
| pair_valid | output | 1 | A left/right pair is waiting |
| pair_left | output | 16 | Left sample, signed |
| pair_right | output | 16 | Right sample, signed |
| sync_err | output | 1 | One-cycle pulse on frame-sync misalignment |
| overrun | output | 1 | One-cycle pulse when an unread pair is lost |

## Verification
Every serial input passes two synchroniser flops, and the update happens on the edge after that. Each result therefore lands on the third system-clock edge after the bit-clock rise that causes it. The bench drives inputs on falling system-clock edges and samples on falling edges. It checks `pair_valid` two falling edges after the final bit-clock rise, where it must still be low, and again one falling edge later, where it must be high. Error pulses are counted on every rising edge. The counts and `pair_valid` are read only after a full half bit period, 8 cycles, has elapsed, which is well past the three-edge latency.

// File: rtl/i2s64_rx_pkg.sv
package i2s64_rx_pkg;
  typedef enum logic {
    TRK_HUNT,
    TRK_RUN
  } trk_state_e;
endpackage

// File: rtl/i2s64_edge_sync.sv
// Oversamples the serial inputs and marks each bit-clock rising edge.
module i2s64_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic fsync_i,
  input  logic sdata_i,
  output logic bit_tick,
  output logic fs_q,
  output logic sd_q
);
  localparam int LANES = 3;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    logic [LANES-1:0] d;
    logic [LANES-1:0] q;
    if (g == 0) begin : g_src
      assign d = {bclk_i, fsync_i, sdata_i};
    end else begin : g_chain
      assign d = g_stage[g-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 3'b110;
      else        q <= d;
    end
  end

  logic [LANES-1:0] last_q;
  logic             bclk_prev;

  assign last_q = g_stage[SYNC_STAGES-1].q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_prev <= 1'b1;
    else        bclk_prev <= last_q[2];
  end

  assign bit_tick = last_q[2] & ~bclk_prev;
  assign fs_q     = last_q[1];
  assign sd_q     = last_q[0];
endmodule

// File: rtl/i2s64_frame_tracker.sv
// Follows the bit position in the frame and checks frame sync on every bit.
module i2s64_frame_tracker
  import i2s64_rx_pkg::*;
#(
  parameter int SLOT_W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic fs_q,
  input  logic ovf_req,
  output logic left_done,
  output logic right_done,
  output logic bad_bit,
  output logic sync_err_o
);
  localparam int FRAME_W = 2 * SLOT_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(SLOT_W - 1);
  localparam logic [CNT_W-1:0] LAST_R = CNT_W'(FRAME_W - 1);

  trk_state_e       state;
  logic [CNT_W-1:0] pos;
  logic             fs_prev;
  logic             fs_rise;
  logic             expect_fs;
  logic             running;
  logic             good_bit;

  assign fs_rise    = fs_q & ~fs_prev;
  assign expect_fs  = (pos <= LAST_L);
  assign running    = (state == TRK_RUN);
  assign bad_bit    = bit_tick & running & (fs_q != expect_fs);
  assign good_bit   = bit_tick & running & ~bad_bit;
  assign left_done  = good_bit & (pos == LAST_L);
  assign right_done = good_bit & (pos == LAST_R);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= TRK_HUNT;
      pos        <= '0;
      fs_prev    <= 1'b1;
      sync_err_o <= 1'b0;
    end else begin
      sync_err_o <= 1'b0;
      if (bit_tick) begin
        fs_prev <= fs_q;
        if (!running) begin
          if (fs_rise) begin
            state <= TRK_RUN;
            pos   <= CNT_W'(1);
          end
        end else if (bad_bit) begin
          sync_err_o <= 1'b1;
          if (fs_rise) pos <= CNT_W'(1);
          else         state <= TRK_HUNT;
        end else if (ovf_req) begin
          state <= TRK_HUNT;
        end else begin
          pos <= pos + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/i2s64_slot_capture.sv
// Shifts serial data, keeps the low bits of each slot, drives the pair stream.
module i2s64_slot_capture #(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_tick,
  input  logic                       sd_q,
  input  logic                       left_done,
  input  logic                       right_done,
  input  logic                       drop,
  input  logic                       out_ready,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right,
  output logic                       ovf_req,
  output logic                       overrun_o
);
  logic [SAMPLE_W-1:0] shreg;
  logic [SAMPLE_W-1:0] shreg_nxt;
  logic [SAMPLE_W-1:0] left_hold;

  assign shreg_nxt = {shreg[SAMPLE_W-2:0], sd_q};
  assign ovf_req   = right_done & out_valid & ~out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      left_hold <= '0;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
      overrun_o <= 1'b0;
    end else begin
      overrun_o <= 1'b0;
      if (bit_tick)  shreg     <= shreg_nxt;
      if (left_done) left_hold <= shreg_nxt;
      if (drop) begin
        out_valid <= 1'b0;
      end else if (ovf_req) begin
        out_valid <= 1'b0;
        overrun_o <= 1'b1;
      end else if (right_done) begin
        out_valid <= 1'b1;
        out_left  <= left_hold;
        out_right <= shreg_nxt;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2s64_slot_rx.sv
module i2s64_slot_rx #(
  parameter int SLOT_W      = 32,
  parameter int SAMPLE_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bclk_i,
  input  logic                       fsync_i,
  input  logic                       sdata_i,
  input  logic                       pair_ready,
  output logic                       pair_valid,
  output logic signed [SAMPLE_W-1:0] pair_left,
  output logic signed [SAMPLE_W-1:0] pair_right,
  output logic                       sync_err,
  output logic                       overrun
);
  logic bit_tick, fs_q, sd_q;
  logic left_done, right_done, bad_bit, ovf_req;

  i2s64_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk_i   (bclk_i),
    .fsync_i  (fsync_i),
    .sdata_i  (sdata_i),
    .bit_tick (bit_tick),
    .fs_q     (fs_q),
    .sd_q     (sd_q)
  );

  i2s64_frame_tracker #(.SLOT_W(SLOT_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .fs_q       (fs_q),
    .ovf_req    (ovf_req),
    .left_done  (left_done),
    .right_done (right_done),
    .bad_bit    (bad_bit),
    .sync_err_o (sync_err)
  );

  i2s64_slot_capture #(.SAMPLE_W(SAMPLE_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .sd_q       (sd_q),
    .left_done  (left_done),
    .right_done (right_done),
    .drop       (bad_bit),
    .out_ready  (pair_ready),
    .out_valid  (pair_valid),
    .out_left   (pair_left),
    .out_right  (pair_right),
    .ovf_req    (ovf_req),
    .overrun_o  (overrun)
  );
endmodule

// File: rtl/i2s64_slot_rx_chk.sv
module i2s64_slot_rx_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pair_ready,
  input logic                pair_valid,
  input logic [SAMPLE_W-1:0] pair_left,
  input logic [SAMPLE_W-1:0] pair_right,
  input logic                sync_err,
  input logic                overrun
);
  // R6
  hold_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && !pair_ready |=>
      (pair_valid && $stable(pair_left) && $stable(pair_right)) || sync_err || overrun);

  // R6
  single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && pair_ready |=> !pair_valid);

  // R8
  err_drops_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> !pair_valid);

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> !sync_err);

  // R7
  ovf_drops_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !pair_valid);

  // R7
  ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun);
endmodule

bind i2s64_slot_rx i2s64_slot_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pair_ready (pair_ready),
  .pair_valid (pair_valid),
  .pair_left  (pair_left),
  .pair_right (pair_right),
  .sync_err   (sync_err),
  .overrun    (overrun)
);

// File: tb/test_i2s64_slot_rx.sv
module test_i2s64_slot_rx;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0;
  logic        fsync = 1'b0;
  logic        sdata = 1'b0;
  logic        ready = 1'b0;
  logic        valid;
  logic [15:0] left_s, right_s;
  logic        sync_err, overrun;

  int checks = 0;
  int errors = 0;
  int n_sync = 0;
  int n_ovf  = 0;
  logic lat_before, lat_after;

  always #10 clk = ~clk;

  i2s64_slot_rx i_i2s64_slot_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_i     (bclk),
    .fsync_i    (fsync),
    .sdata_i    (sdata),
    .pair_ready (ready),
    .pair_valid (valid),
    .pair_left  (left_s),
    .pair_right (right_s),
    .sync_err   (sync_err),
    .overrun    (overrun)
  );

  always @(posedge clk) begin
    if (sync_err) n_sync++;
    if (overrun)  n_ovf++;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One bit period; with scramble, fs and data flip while the bit clock is high.
  task automatic put_bit(input logic f, input logic d, input bit scramble);
    @(negedge clk);
    bclk = 1'b0; fsync = f; sdata = d;
    repeat (HALF) @(negedge clk);
    bclk = 1'b1;
    if (scramble) begin
      repeat (4) @(negedge clk);
      fsync = ~f; sdata = ~d;
      repeat (HALF - 5) @(negedge clk);
    end else begin
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  task automatic put_bits(input int n, input logic f);
    for (int i = 0; i < n; i++) put_bit(f, i[0], 1'b0);
  endtask

  task automatic send_frame(input logic [31:0] l, input logic [31:0] r, input bit scramble);
    for (int i = 0; i < 63; i++)
      put_bit(i < 32, (i < 32) ? l[31-i] : r[63-i], scramble);
    @(negedge clk);
    bclk = 1'b0; fsync = 1'b0; sdata = r[0];
    repeat (HALF) @(negedge clk);
    bclk = 1'b1;
    repeat (2) @(negedge clk);
    lat_before = valid;
    @(negedge clk);
    lat_after = valid;
    repeat (HALF - 3) @(negedge clk);
  endtask

  task automatic check_pair(input string req, input logic [31:0] l, input logic [31:0] r);
    chk(req, "pair_valid", {31'd0, valid}, 32'd1);
    chk(req, "left", {16'd0, left_s}, {16'd0, l[15:0]});
    chk(req, "right", {16'd0, right_s}, {16'd0, r[15:0]});
  endtask

  task automatic pop();
    @(negedge clk); ready = 1'b1;
    @(negedge clk); ready = 1'b0;
    chk("R6", "valid after transfer", {31'd0, valid}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "valid at reset", {31'd0, valid}, 32'd0);
    chk("R1", "sync_err at reset", {31'd0, sync_err}, 32'd0);
    chk("R1", "overrun at reset", {31'd0, overrun}, 32'd0);
  endtask

  task automatic t_startup_partial();
    put_bits(20, 1'b1);
    put_bits(32, 1'b0);
    chk("R1", "no pair from partial frame", {31'd0, valid}, 32'd0);
    chk("R1", "no error while hunting", n_sync, 0);
    send_frame(32'hABCD_1234, 32'h5555_8001, 1'b0);
    check_pair("R1", 32'hABCD_1234, 32'h5555_8001);
    pop();
  endtask

  task automatic t_patterns();
    send_frame(32'hFFFF_7FFF, 32'h0000_FFFF, 1'b0);
    chk("R5", "valid low before third edge", {31'd0, lat_before}, 32'd0);
    chk("R5", "valid high at third edge", {31'd0, lat_after}, 32'd1);
    check_pair("R3", 32'hFFFF_7FFF, 32'h0000_FFFF);
    pop();
    send_frame(32'h1234_0000, 32'hDEAD_C3A5, 1'b0);
    check_pair("R4", 32'h1234_0000, 32'hDEAD_C3A5);
    pop();
    send_frame(32'h8000_0001, 32'h7FFF_8000, 1'b1);
    check_pair("R2", 32'h8000_0001, 32'h7FFF_8000);
    chk("R2", "no error from high-phase changes", n_sync, 0);
    pop();
  endtask

  task automatic t_hold();
    send_frame(32'h0F0F_A5A5, 32'hF0F0_5A5A, 1'b0);
    repeat (30) @(negedge clk);
    check_pair("R6", 32'h0F0F_A5A5, 32'hF0F0_5A5A);
  endtask

  task automatic t_sync_fall_early();
    int base = n_sync;
    put_bits(20, 1'b1);
    put_bits(44, 1'b0);
    chk("R8", "sync_err pulses", n_sync, base + 1);
    chk("R8", "waiting pair dropped", {31'd0, valid}, 32'd0);
    send_frame(32'h0000_2468, 32'h0000_1357, 1'b0);
    check_pair("R8", 32'h0000_2468, 32'h0000_1357);
    pop();
  endtask

  task automatic t_early_start();
    int base = n_sync;
    put_bits(32, 1'b1);
    put_bits(8, 1'b0);
    send_frame(32'h3333_CAFE, 32'h4444_BEEF, 1'b0);
    chk("R9", "early rise flagged", n_sync, base + 1);
    check_pair("R9", 32'h3333_CAFE, 32'h4444_BEEF);
    pop();
  endtask

  task automatic t_missing_rise();
    int base = n_sync;
    put_bits(64, 1'b0);
    chk("R8", "missing rise flagged", n_sync, base + 1);
    chk("R8", "no pair after missing rise", {31'd0, valid}, 32'd0);
    send_frame(32'h9999_0102, 32'h8888_0304, 1'b0);
    check_pair("R9", 32'h9999_0102, 32'h8888_0304);
    pop();
  endtask

  task automatic t_overrun();
    int base = n_ovf;
    send_frame(32'h0000_1111, 32'h0000_2222, 1'b0);
    send_frame(32'h0000_3333, 32'h0000_4444, 1'b0);
    chk("R7", "overrun pulses", n_ovf, base + 1);
    chk("R7", "pair dropped on overrun", {31'd0, valid}, 32'd0);
    send_frame(32'h0000_5555, 32'h0000_6666, 1'b0);
    check_pair("R7", 32'h0000_5555, 32'h0000_6666);
    pop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_startup_partial();
    t_patterns();
    t_hold();
    t_sync_fall_early();
    t_early_start();
    t_missing_rise();
    t_overrun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule